// File: doc/BRIEF.md
# Transition-Shaping Element Selector for a Multi-Bit Delta-Sigma DAC

This block decides, once per accepted sample, which of the `N_ELEM` unit elements of a multi-bit delta-sigma DAC are switched on. The sample is an integer code from 0 to `N_ELEM`. The output is a selection vector that holds exactly that many ones. Two sets of per-element integrators steer the choice. The usage integrators shape the static element mismatch by tracking how often each element has been selected. The transition integrators shape inter-symbol interference by tracking how often each element changes state in either direction, rising or falling, and pull that rate toward a fixed target.

For each element, the block adds the usage filter output, the transition filter output scaled by a run-time gain, and an external signed dither value. The elements are ranked on that sum, and the lowest-ranked ones are switched on. Both loop filters are either a delayed accumulator or a delayed double accumulator with a proportional path, chosen at build time. The modulator that produces the code and the analog element array are outside the block. A two-state machine, PH_IDLE and PH_EMIT, marks output samples. An accepted input moves it to PH_EMIT (or keeps it there). A cycle with no input moves it to PH_IDLE (or keeps it there).

Top module: `isi_shaping_encoder`

## Requirements
- R1: For every accepted sample, `out_sel` carries exactly min(`in_code`, `N_ELEM`) ones.
- R2: `out_valid` is high in the cycle after each cycle with `in_valid` high and low after each cycle without it, and `out_sel` changes on that same edge (one-cycle latency).
- R3: A cycle without `in_valid` leaves `out_sel` and every integrator unchanged; the next accepted sample is encoded exactly as if the idle cycle had not occurred.
- R4: Synchronous reset clears all integrators, clears the previous selection to zero and drives `out_valid` low; the first sample after reset with zero dither and code k selects elements 0 to k-1.
- R5: A code above `N_ELEM` is clamped to `N_ELEM`: all elements are switched on, and the clamped value is used as the mean in the usage loop.
- R6: Element i gets the priority P_i = U_i + D_i·g·T_i + d_i. Here U_i and T_i are the usage and transition filter outputs, g is `in_gain` (unsigned), d_i is the signed dither at bits [i·DITHER_W +: DITHER_W], and D_i is −1 if element i was on in the previous sample and +1 otherwise. The k elements with the lowest P_i are switched on. On equal P_i, the lower index wins.
- R7: After each accepted sample, the usage integrator input of element i is N_ELEM·s_i − k, where k is the clamped code.
- R8: The transition flag of element i is its previous selection bit XOR its new one. The transition integrator input is N_ELEM·t_i − TRANS_TGT, so the target rate per element is TRANS_TGT/N_ELEM.
- R9: With LOOP_ORDER 1, each filter output is a1, where a1 accumulates the input with one sample of delay. With LOOP_ORDER 2, the output is a2 + 4·a1, where a2 accumulates the updated a1.
- R10: Every integrator saturates symmetrically at ±(2^(STATE_W−1) − 1).
- R11: With gain 0 and zero dither from reset, the selection counts of any two elements differ by at most 1 at all times.
- R12: The gain is taken from `in_gain` on each sample, so changing it between samples changes the selection accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample accepted this cycle |
| in_code | input | CODE_W | Number of elements to switch on |
| in_gain | input | GAIN_W | Transition-loop gain, unsigned |
| in_dither | input | N_ELEM·DITHER_W | Signed dither per element, element i at bits [i·DITHER_W +: DITHER_W] |
| out_valid | output | 1 | out_sel holds a new sample |
| out_sel | output | N_ELEM | Element selection vector |

## Verification
Two instances are driven together: a first-order one with wide integrators and a second-order one with narrow integrators. Each is compared every cycle against a behavioural integer model. A gain-zero sweep over all codes isolates the usage loop and confirms its tight balance. A constant mid-scale code with gain 2 exercises the transition loop, and the two loop orders must diverge as the model predicts. Random codes, gains and dither test the ranking, the tie rules and the run-time gain. A long full-scale run drives the narrow integrators into saturation, which only a correctly clipped state survives. Empty, full-scale, over-range and idle cycles pin down the boundaries.

// File: rtl/isi_enc_pkg.sv
package isi_enc_pkg;

    // Output-phase state of the encoder
    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_EMIT = 1'b1
    } enc_phase_e;

endpackage

// File: rtl/isi_loop_filter.sv
// Per-element saturating loop filter: first order is a delayed accumulator,
// second order adds a double accumulator to four times the first stage.
module isi_loop_filter #(
    parameter int LOOP_ORDER = 1,
    parameter int STATE_W    = 16,
    parameter int IN_W       = 8,
    parameter int OUT_W      = STATE_W + 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] y
);

    localparam int MAXI = (1 << (STATE_W - 1)) - 1;
    localparam logic signed [STATE_W+1:0] MAXV = (STATE_W + 2)'(MAXI);
    localparam logic signed [STATE_W+1:0] MINV = -MAXV;

    function automatic logic signed [STATE_W-1:0] clip(input logic signed [STATE_W+1:0] v);
        if (v > MAXV)
            clip = MAXV[STATE_W-1:0];
        else if (v < MINV)
            clip = MINV[STATE_W-1:0];
        else
            clip = v[STATE_W-1:0];
    endfunction

    logic signed [STATE_W-1:0] a1_q, a1_d;

    always_comb a1_d = clip((STATE_W + 2)'(a1_q) + (STATE_W + 2)'(x));

    always_ff @(posedge clk) begin
        if (rst)
            a1_q <= '0;
        else if (en)
            a1_q <= a1_d;
    end

    generate
        if (LOOP_ORDER == 1) begin : g_first
            assign y = OUT_W'(a1_q);
        end else begin : g_second
            logic signed [STATE_W-1:0] a2_q, a2_d;
            always_comb a2_d = clip((STATE_W + 2)'(a2_q) + (STATE_W + 2)'(a1_d));
            always_ff @(posedge clk) begin
                if (rst)
                    a2_q <= '0;
                else if (en)
                    a2_q <= a2_d;
            end
            assign y = OUT_W'(a2_q) + (OUT_W'(a1_q) <<< 2);

            a_r3_second_hold: assert property (@(posedge clk) disable iff (rst)
                !en |=> $stable(a2_q));
        end
    endgenerate

    // R3: state frozen while no sample is accepted
    a_r3_state_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(a1_q));

    // R10: accepted step never leaves the clip range
    a_r10_in_range: assert property (@(posedge clk) disable iff (rst)
        en |=> ((STATE_W + 2)'(a1_q) <= MAXV) && ((STATE_W + 2)'(a1_q) >= MINV));

endmodule

// File: rtl/isi_rank_select.sv
// Pairwise ranking: element i is switched on when fewer than quota elements
// rank ahead of it (lower priority value, or equal value and lower index).
module isi_rank_select #(
    parameter int N_ELEM = 32,
    parameter int PRIO_W = 25,
    parameter int CODE_W = 6
) (
    input  logic [N_ELEM*PRIO_W-1:0] prio,
    input  logic [CODE_W-1:0]        quota,
    output logic [N_ELEM-1:0]        sel
);

    wire [N_ELEM-1:0] ahead [N_ELEM];

    generate
        for (genvar i = 0; i < N_ELEM; i++) begin : g_row
            for (genvar j = 0; j < N_ELEM; j++) begin : g_col
                if (j < i) begin : g_lo
                    assign ahead[i][j] = $signed(prio[j*PRIO_W +: PRIO_W])
                                      <= $signed(prio[i*PRIO_W +: PRIO_W]);
                end else if (j > i) begin : g_hi
                    assign ahead[i][j] = $signed(prio[j*PRIO_W +: PRIO_W])
                                      <  $signed(prio[i*PRIO_W +: PRIO_W]);
                end else begin : g_self
                    assign ahead[i][j] = 1'b0;
                end
            end
            assign sel[i] = $countones(ahead[i]) < int'(quota);
        end
    endgenerate

    // R1: exactly quota elements chosen (quota is already clamped)
    always_comb begin
        a_r1_rank_count: assert ($countones(sel) == int'(quota) || int'(quota) > N_ELEM);
    end

endmodule

// File: rtl/isi_shaping_encoder.sv
module isi_shaping_encoder
    import isi_enc_pkg::*;
#(
    parameter int N_ELEM     = 32,
    parameter int LOOP_ORDER = 1,
    parameter int STATE_W    = 16,
    parameter int GAIN_W     = 4,
    parameter int DITHER_W   = 4,
    parameter int TRANS_TGT  = N_ELEM / 2,
    parameter int CODE_W     = $clog2(N_ELEM + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [CODE_W-1:0]            in_code,
    input  logic [GAIN_W-1:0]            in_gain,
    input  logic [N_ELEM*DITHER_W-1:0]   in_dither,
    output logic                         out_valid,
    output logic [N_ELEM-1:0]            out_sel
);

    localparam int XW     = $clog2(N_ELEM) + 3;
    localparam int OW     = STATE_W + 3;
    localparam int PRIO_W = OW + GAIN_W + 3;

    enc_phase_e                phase_q, phase_d;
    logic [N_ELEM-1:0]         sel_q, sel_nxt;
    logic [CODE_W-1:0]         code_eff;
    logic [N_ELEM*PRIO_W-1:0]  prio_flat;

    assign code_eff = (in_code > CODE_W'(N_ELEM)) ? CODE_W'(N_ELEM) : in_code;

    generate
        for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
            logic signed [XW-1:0]     x_use, x_trn;
            logic signed [OW-1:0]     f_use, f_trn;
            logic signed [PRIO_W-1:0] g_trn, pr;

            assign x_use = (sel_nxt[i] ? XW'(N_ELEM) : XW'(0)) - XW'(code_eff);
            assign x_trn = ((sel_q[i] ^ sel_nxt[i]) ? XW'(N_ELEM) : XW'(0)) - XW'(TRANS_TGT);

            isi_loop_filter #(
                .LOOP_ORDER(LOOP_ORDER), .STATE_W(STATE_W), .IN_W(XW), .OUT_W(OW)
            ) u_use (
                .clk(clk), .rst(rst), .en(in_valid), .x(x_use), .y(f_use)
            );

            isi_loop_filter #(
                .LOOP_ORDER(LOOP_ORDER), .STATE_W(STATE_W), .IN_W(XW), .OUT_W(OW)
            ) u_trn (
                .clk(clk), .rst(rst), .en(in_valid), .x(x_trn), .y(f_trn)
            );

            assign g_trn = PRIO_W'($signed({1'b0, in_gain}) * f_trn);
            assign pr    = PRIO_W'(f_use) + (sel_q[i] ? -g_trn : g_trn)
                         + PRIO_W'($signed(in_dither[i*DITHER_W +: DITHER_W]));
            assign prio_flat[i*PRIO_W +: PRIO_W] = pr;
        end
    endgenerate

    isi_rank_select #(
        .N_ELEM(N_ELEM), .PRIO_W(PRIO_W), .CODE_W(CODE_W)
    ) u_rank (
        .prio(prio_flat), .quota(code_eff), .sel(sel_nxt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    // Next state and output data
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (in_valid)  phase_d = PH_EMIT;
            PH_EMIT: if (!in_valid) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (in_valid)
            sel_q <= sel_nxt;
    end

    assign out_valid = (phase_q == PH_EMIT);
    assign out_sel   = sel_q;

    // R1: population of the output equals the clamped code
    a_r1_popcount: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ($countones(out_sel) == int'($past(code_eff))));

    // R2: one-cycle latency of the valid flag
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3: output held while idle
    a_r3_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sel));

    // R5: over-range or full code turns everything on
    a_r5_full_scale: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_code >= CODE_W'(N_ELEM)) |=> (&out_sel));

endmodule

// File: tb/test_isi_shaping_encoder.sv
`timescale 1ns/1ps
module test_isi_shaping_encoder;

    localparam int NE   = 32;
    localparam int CW   = $clog2(NE + 1);
    localparam int TGT  = NE / 2;
    localparam int DWW  = 4;

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [CW-1:0] in_code;
    logic [3:0] in_gain;
    logic [NE*DWW-1:0] in_dither;
    logic ov0, ov1;
    logic [NE-1:0] os0, os1;

    always #4 clk = ~clk;

    isi_shaping_encoder #(.N_ELEM(NE), .LOOP_ORDER(1), .STATE_W(16)) i_isi_shaping_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code), .in_gain(in_gain),
        .in_dither(in_dither), .out_valid(ov0), .out_sel(os0)
    );

    isi_shaping_encoder #(.N_ELEM(NE), .LOOP_ORDER(2), .STATE_W(10)) i_isi_shaping_encoder_o2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code), .in_gain(in_gain),
        .in_dither(in_dither), .out_valid(ov1), .out_sel(os1)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int a1m [2][NE];
    int a2m [2][NE];
    int a1t [2][NE];
    int a2t [2][NE];
    int prv [2][NE];
    int dith [NE];
    int usage [NE];
    bit spread_on;
    logic [NE-1:0] last0, last1;
    int unsigned seed = 32'h1234_5678;

    function automatic int clipv(int v, int mx);
        return (v > mx) ? mx : ((v < -mx) ? -mx : v);
    endfunction

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: integer priorities, explicit rank counting
    task automatic model(input int k, input int code, input int g, output logic [NE-1:0] s);
        int ord, mx, ye;
        int p [NE];
        ord = k + 1;
        mx  = (k == 0) ? 32767 : 511;
        ye  = (code > NE) ? NE : code;
        for (int i = 0; i < NE; i++) begin
            int fu, ft;
            fu = (ord == 1) ? a1m[k][i] : a2m[k][i] + 4 * a1m[k][i];
            ft = (ord == 1) ? a1t[k][i] : a2t[k][i] + 4 * a1t[k][i];
            p[i] = fu + (prv[k][i] != 0 ? -g * ft : g * ft) + dith[i];
        end
        for (int i = 0; i < NE; i++) begin
            int r;
            r = 0;
            for (int j = 0; j < NE; j++)
                if (p[j] < p[i] || (p[j] == p[i] && j < i)) r++;
            s[i] = (r < ye);
        end
        for (int i = 0; i < NE; i++) begin
            int xu, xt, t;
            t  = (prv[k][i] != int'(s[i])) ? 1 : 0;
            xu = NE * int'(s[i]) - ye;
            xt = NE * t - TGT;
            a1m[k][i] = clipv(a1m[k][i] + xu, mx);
            a2m[k][i] = clipv(a2m[k][i] + a1m[k][i], mx);
            a1t[k][i] = clipv(a1t[k][i] + xt, mx);
            a2t[k][i] = clipv(a2t[k][i] + a1t[k][i], mx);
            prv[k][i] = int'(s[i]);
        end
    endtask

    // Called just after a falling edge; returns just after the next one
    task automatic step(input int code, input int g, input bit vld, input string tag);
        logic [NE-1:0] e0, e1;
        int ye;
        in_valid = vld;
        in_code  = CW'(code);
        in_gain  = 4'(g);
        for (int i = 0; i < NE; i++) in_dither[i*DWW +: DWW] = DWW'(dith[i]);
        if (vld) begin
            model(0, code, g, e0);
            model(1, code, g, e1);
        end else begin
            e0 = last0;
            e1 = last1;
        end
        @(posedge clk);
        @(negedge clk);
        ye = (code > NE) ? NE : code;
        chk(ov0 == vld && ov1 == vld, "R2 out_valid", {ov1, ov0}, {vld, vld});
        chk(os0 == e0, {tag, " order1 selection"}, os0, e0);
        chk(os1 == e1, {tag, " order2 selection"}, os1, e1);
        if (vld) begin
            chk($countones(os0) == ye && $countones(os1) == ye, "R1 popcount",
                $countones(os0), ye);
            for (int i = 0; i < NE; i++) usage[i] += int'(os0[i]);
        end
        if (spread_on) begin
            int mn, mxu;
            mn = usage[0]; mxu = usage[0];
            for (int i = 1; i < NE; i++) begin
                if (usage[i] < mn) mn = usage[i];
                if (usage[i] > mxu) mxu = usage[i];
            end
            chk(mxu - mn <= 1, "R11 usage spread", mxu - mn, 1);
        end
        last0 = os0;
        last1 = os1;
    endtask

    initial begin
        #(150000 * 8);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < NE; i++) begin
                a1m[k][i] = 0; a2m[k][i] = 0; a1t[k][i] = 0; a2t[k][i] = 0; prv[k][i] = 0;
            end
        for (int i = 0; i < NE; i++) begin dith[i] = 0; usage[i] = 0; end
        spread_on = 1'b0;
        rst = 1'b1; in_valid = 1'b0; in_code = '0; in_gain = '0; in_dither = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R4: reset state
        chk(ov0 == 1'b0 && os0 == '0 && ov1 == 1'b0 && os1 == '0, "R4 reset outputs",
            {ov0, os0}, 0);
        rst = 1'b0;

        // R4: first sample after reset picks the lowest indices
        step(5, 2, 1'b1, "R4");
        chk(os0 == 32'h1F && os1 == 32'h1F, "R4 first selection", os0, 32'h1F);

        // R7 R11: usage loop alone over a code sweep
        spread_on = 1'b1;
        for (int n = 0; n < 330; n++) step((n * 7) % (NE + 1), 0, 1'b1, "R7");
        spread_on = 1'b0;

        // R3: idle cycles keep output and state
        for (int n = 0; n < 3; n++) step(9, 3, 1'b0, "R3");
        step(9, 0, 1'b1, "R3 resume");

        // R8 R9: constant mid-scale code, transition loop active
        for (int n = 0; n < 400; n++) step(NE / 2, 2, 1'b1, "R8");

        // R6 R12: random codes, gains and dither
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < NE; i++) dith[i] = int'(rnd() % 16) - 8;
            step(int'(rnd() % (NE + 1)), int'(rnd() % 16), 1'b1, "R6 R12");
        end
        for (int i = 0; i < NE; i++) dith[i] = 0;

        // R1 R5: empty, full and over-range codes
        step(0, 2, 1'b1, "R1 empty");
        chk(os0 == '0, "R1 empty code", os0, 0);
        step(40, 2, 1'b1, "R5 over-range");
        chk(&os0 && &os1, "R5 clamp all on", os0, {NE{1'b1}});
        step(NE, 2, 1'b1, "R5 full");

        // R10: long full-scale run saturates the narrow integrators
        for (int n = 0; n < 80; n++) step(NE, 0, 1'b1, "R10");
        for (int n = 0; n < 150; n++) step(int'(rnd() % (NE + 1)), 3, 1'b1, "R10 recovery");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule